// File: doc/BRIEF.md
# Pattern Pulse-Width Trigger Qualifier

This block watches a bus of digital channels and builds one pattern bit from it. Each channel either takes part or is ignored. A channel that takes part must equal its programmed level. The pattern is true only when every channel that takes part matches. A polarity input picks whether the block measures the time the pattern spends true or the time it spends false. That time is counted in whole system clock cycles. A pulse of one clock cycle is the shortest width the block can detect.

A mode input picks one of four rules. Three of the rules judge a pulse once it has ended. They fire when the width is below a limit, above a limit, or strictly between a lower and an upper limit. The fourth rule is a timeout. It fires while the pattern is still in the measured state, at the first cycle where the running width goes past the limit. The limits are cycle counts. The result is a single-cycle trigger pulse that a capture engine can use to stop or start an acquisition.

Top module: `pwq_trigger`

## Requirements
- R1: A channel takes part in the pattern when its `sel_mask_i` bit is 1, and then it must equal its `level_i` bit. Channels whose mask bit is 0 are ignored. With an all-zero mask the pattern is always true.
- R2: With `meas_false_i` = 0 the block measures the time the pattern is true. With `meas_false_i` = 1 it measures the time the pattern is false.
- R3: Mode code 0 (shorter-than): when a pulse ends with a width below `lim_lo_i`, the trigger is high in the cycle after the clock edge where the pattern leaves the measured state.
- R4: Mode code 1 (longer-than): when a pulse ends with a width above `lim_lo_i`, the trigger is high in the cycle after the exit edge.
- R5: Mode code 2 (window): when a pulse ends with a width greater than `lim_lo_i` and smaller than `lim_hi_i`, the trigger is high in the cycle after the exit edge. If `lim_lo_i` >= `lim_hi_i` the trigger never fires.
- R6: Mode code 3 (timeout): the trigger is high in the cycle after the first edge where the running width exceeds `lim_lo_i`. It fires once per pulse and does not wait for the pulse to end.
- R7: The width is the number of consecutive rising clock edges at which the pattern was sampled in the measured state. A one-edge pulse has width 1, and the count restarts at 1 for each new pulse.
- R8: The width count saturates at 2^CNT_W-1 and never wraps. A very long pulse still reads as longer than any limit.
- R9: `trig_o` is low after reset and every firing lasts exactly one cycle.
- R10: In modes 0, 1 and 2 the trigger never fires while the pattern is still in the measured state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; widths are counted in its cycles |
| rst_ni | input | 1 | Active-low synchronous reset |
| chan_i | input | N_CH | Channel levels |
| sel_mask_i | input | N_CH | 1 = channel takes part in the pattern |
| level_i | input | N_CH | Required level for each channel that takes part |
| meas_false_i | input | 1 | 0 = measure true time, 1 = measure false time |
| mode_i | input | 2 | 0 shorter, 1 longer, 2 window, 3 timeout |
| lim_lo_i | input | CNT_W | Limit T (lower limit in window mode), in cycles |
| lim_hi_i | input | CNT_W | Upper limit in window mode, in cycles |
| trig_o | output | 1 | Single-cycle trigger pulse |

## Verification
The assertions check the counter and trigger rules on every cycle:
- the width steps up by one, restarts at one and holds at saturation;
- no end-of-pulse mode fires mid-pulse;
- an inverted window stays silent;
- a firing is never followed straight away by a second one unless the mode changed.

Only the bench's scenarios show whether the pattern is built correctly from mask, level and polarity, and whether each comparison lands on the correct side of its limit. The exact cycle of each firing and the saturation of a pulse longer than the counter range are likewise shown only by those scenarios.

// File: rtl/pwq_pkg.sv
package pwq_pkg;

  typedef enum logic [1:0] {
    PWQ_SHORTER = 2'd0,
    PWQ_LONGER  = 2'd1,
    PWQ_WINDOW  = 2'd2,
    PWQ_TIMEOUT = 2'd3
  } pwq_mode_e;

  // Saturating increment of a width count of any width up to 32 bits.
  function automatic logic [31:0] pwq_sat_inc(input logic [31:0] cur, input logic [31:0] top);
    if (cur >= top) return top;
    return cur + 32'd1;
  endfunction

  // Judgement of a completed width for the end-of-pulse modes.
  function automatic logic pwq_width_ok(input pwq_mode_e mode, input logic [31:0] width,
                                        input logic [31:0] lo, input logic [31:0] hi);
    logic ok;
    case (mode)
      PWQ_SHORTER: ok = (width < lo);
      PWQ_LONGER:  ok = (width > lo);
      PWQ_WINDOW:  ok = (lo < hi) && (width > lo) && (width < hi);
      default:     ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pwq_pattern.sv
module pwq_pattern #(
  parameter int N_CH = 8
) (
  input  logic [N_CH-1:0] chan_i,
  input  logic [N_CH-1:0] sel_mask_i,
  input  logic [N_CH-1:0] level_i,
  input  logic            meas_false_i,
  output logic            in_state_o
);
  logic [N_CH-1:0] hit;

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    assign hit[g] = ~sel_mask_i[g] | (chan_i[g] ~^ level_i[g]);
  end

  logic pattern_true;
  assign pattern_true = &hit;
  assign in_state_o   = pattern_true ^ meas_false_i;
endmodule

// File: rtl/pwq_width_ctr.sv
module pwq_width_ctr
  import pwq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_state_i,
  output logic             run_q_o,
  output logic [CNT_W-1:0] width_q_o,
  output logic [CNT_W-1:0] width_next_o,
  output logic             pulse_end_o
);
  localparam logic [31:0] CNT_TOP = 32'((64'd1 << CNT_W) - 64'd1);

  logic             run_q;
  logic [CNT_W-1:0] width_q;
  logic [CNT_W-1:0] width_next;

  always_comb begin
    if (!in_state_i)  width_next = '0;
    else if (!run_q)  width_next = CNT_W'(1);
    else              width_next = CNT_W'(pwq_sat_inc(32'(width_q), CNT_TOP));
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      width_q <= '0;
    end else begin
      run_q   <= in_state_i;
      width_q <= width_next;
    end
  end

  assign run_q_o      = run_q;
  assign width_q_o    = width_q;
  assign width_next_o = width_next;
  assign pulse_end_o  = run_q & ~in_state_i;
endmodule

// File: rtl/pwq_judge.sv
module pwq_judge
  import pwq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] lim_lo_i,
  input  logic [CNT_W-1:0] lim_hi_i,
  input  logic             in_state_i,
  input  logic             pulse_end_i,
  input  logic [CNT_W-1:0] width_q_i,
  input  logic [CNT_W-1:0] width_next_i,
  output logic             end_fire_o,
  output logic             tmo_fire_o,
  output logic             trig_o
);
  pwq_mode_e mode;
  assign mode = pwq_mode_e'(mode_i);

  logic tmo_done_q;
  logic end_fire;
  logic tmo_fire;
  logic trig_q;

  assign end_fire = pulse_end_i && (mode != PWQ_TIMEOUT) &&
                    pwq_width_ok(mode, 32'(width_q_i), 32'(lim_lo_i), 32'(lim_hi_i));
  assign tmo_fire = (mode == PWQ_TIMEOUT) && in_state_i && !tmo_done_q &&
                    (width_next_i > lim_lo_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      tmo_done_q <= 1'b0;
      trig_q     <= 1'b0;
    end else begin
      tmo_done_q <= in_state_i & (tmo_done_q | tmo_fire);
      trig_q     <= end_fire | tmo_fire;
    end
  end

  assign end_fire_o = end_fire;
  assign tmo_fire_o = tmo_fire;
  assign trig_o     = trig_q;
endmodule

// File: rtl/pwq_trigger.sv
module pwq_trigger #(
  parameter int N_CH  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  chan_i,
  input  logic [N_CH-1:0]  sel_mask_i,
  input  logic [N_CH-1:0]  level_i,
  input  logic             meas_false_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] lim_lo_i,
  input  logic [CNT_W-1:0] lim_hi_i,
  output logic             trig_o
);
  logic             in_state;
  logic             run_q;
  logic [CNT_W-1:0] width_q;
  logic [CNT_W-1:0] width_next;
  logic             pulse_end;
  logic             end_fire;
  logic             tmo_fire;

  pwq_pattern #(.N_CH(N_CH)) u_pattern (
    .chan_i       (chan_i),
    .sel_mask_i   (sel_mask_i),
    .level_i      (level_i),
    .meas_false_i (meas_false_i),
    .in_state_o   (in_state)
  );

  pwq_width_ctr #(.CNT_W(CNT_W)) u_width (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_state_i   (in_state),
    .run_q_o      (run_q),
    .width_q_o    (width_q),
    .width_next_o (width_next),
    .pulse_end_o  (pulse_end)
  );

  pwq_judge #(.CNT_W(CNT_W)) u_judge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .lim_lo_i     (lim_lo_i),
    .lim_hi_i     (lim_hi_i),
    .in_state_i   (in_state),
    .pulse_end_i  (pulse_end),
    .width_q_i    (width_q),
    .width_next_i (width_next),
    .end_fire_o   (end_fire),
    .tmo_fire_o   (tmo_fire),
    .trig_o       (trig_o)
  );
endmodule

// File: rtl/pwq_checker.sv
module pwq_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] lim_lo_i,
  input logic [CNT_W-1:0] lim_hi_i,
  input logic             trig_o,
  input logic             in_state,
  input logic             run_q,
  input logic [CNT_W-1:0] width_q
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_WIDTH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && in_state && width_q != TOP) |=> (width_q == $past(width_q) + 1'b1)); // R7

  AST_WIDTH_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_state && !run_q) |=> (width_q == 1)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && in_state && width_q == TOP) |=> (width_q == TOP)); // R8

  AST_NO_MIDPULSE_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd3 && in_state) |=> !trig_o); // R10

  AST_BAD_WINDOW_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && lim_lo_i >= lim_hi_i) |=> !trig_o); // R5

  AST_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> (!trig_o || !$stable(mode_i))); // R9
endmodule

bind pwq_trigger pwq_checker #(.CNT_W(CNT_W)) u_pwq_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .lim_lo_i (lim_lo_i),
  .lim_hi_i (lim_hi_i),
  .trig_o   (trig_o),
  .in_state (in_state),
  .run_q    (run_q),
  .width_q  (width_q)
);

// File: tb/test_pwq_trigger.sv
module test_pwq_trigger;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH  = 8;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic [1:0]  mode;
    logic        pol;
    logic [7:0]  mask;
    logic [7:0]  lvl;
    logic [7:0]  on;
    logic [7:0]  off;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [31:0] w;
    logic        fire;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 8'hFF, 8'hA5, 8'hA5, 8'hA4, 16'd4, 16'd0, 32'd3,  1'b1, 8'd3},  // R3 below
    '{2'd0, 1'b0, 8'hFF, 8'hA5, 8'hA5, 8'hA4, 16'd4, 16'd0, 32'd4,  1'b0, 8'd3},  // R3 equal
    '{2'd0, 1'b0, 8'hFF, 8'hA5, 8'hA5, 8'h25, 16'd4, 16'd0, 32'd1,  1'b1, 8'd7},  // R7 one cycle
    '{2'd1, 1'b0, 8'hFF, 8'h3C, 8'h3C, 8'h00, 16'd4, 16'd0, 32'd5,  1'b1, 8'd4},  // R4 above
    '{2'd1, 1'b0, 8'hFF, 8'h3C, 8'h3C, 8'h00, 16'd4, 16'd0, 32'd4,  1'b0, 8'd4},  // R4 equal
    '{2'd1, 1'b0, 8'hFF, 8'h3C, 8'h3C, 8'h00, 16'd4, 16'd0, 32'd40, 1'b1, 8'd10}, // R10 long
    '{2'd2, 1'b0, 8'hFF, 8'h11, 8'h11, 8'h10, 16'd2, 16'd5, 32'd3,  1'b1, 8'd5},  // R5 inside
    '{2'd2, 1'b0, 8'hFF, 8'h11, 8'h11, 8'h10, 16'd2, 16'd5, 32'd5,  1'b0, 8'd5},  // R5 upper edge
    '{2'd2, 1'b0, 8'hFF, 8'h11, 8'h11, 8'h10, 16'd2, 16'd5, 32'd2,  1'b0, 8'd5},  // R5 lower edge
    '{2'd2, 1'b0, 8'hFF, 8'h11, 8'h11, 8'h10, 16'd5, 16'd5, 32'd3,  1'b0, 8'd5},  // R5 equal limits
    '{2'd2, 1'b0, 8'hFF, 8'h11, 8'h11, 8'h10, 16'd6, 16'd3, 32'd4,  1'b0, 8'd5},  // R5 inverted
    '{2'd3, 1'b0, 8'hFF, 8'h77, 8'h77, 8'h76, 16'd4, 16'd0, 32'd10, 1'b1, 8'd6},  // R6 early fire
    '{2'd3, 1'b0, 8'hFF, 8'h77, 8'h77, 8'h76, 16'd4, 16'd0, 32'd4,  1'b0, 8'd6},  // R6 not reached
    '{2'd3, 1'b0, 8'hFF, 8'h77, 8'h77, 8'h76, 16'd4, 16'd0, 32'd5,  1'b1, 8'd6},  // R6 just over
    '{2'd1, 1'b1, 8'hFF, 8'h0F, 8'h0E, 8'h0F, 16'd2, 16'd0, 32'd3,  1'b1, 8'd2},  // R2 false time
    '{2'd0, 1'b0, 8'h0F, 8'h03, 8'hF3, 8'h02, 16'd9, 16'd0, 32'd2,  1'b1, 8'd1},  // R1 partial mask
    '{2'd1, 1'b0, 8'h00, 8'h00, 8'h5A, 8'hC3, 16'd1, 16'd0, 32'd6,  1'b0, 8'd1}   // R1 empty mask
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_CH-1:0]  chan_i = '0;
  logic [N_CH-1:0]  sel_mask_i = '0;
  logic [N_CH-1:0]  level_i = '0;
  logic             meas_false_i = 1'b0;
  logic [1:0]       mode_i = '0;
  logic [CNT_W-1:0] lim_lo_i = '0;
  logic [CNT_W-1:0] lim_hi_i = '0;
  logic             trig_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwq_trigger #(.N_CH(N_CH), .CNT_W(CNT_W)) i_pwq_trigger (
    .clk_i, .rst_ni, .chan_i, .sel_mask_i, .level_i, .meas_false_i,
    .mode_i, .lim_lo_i, .lim_hi_i, .trig_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reset, configure, idle, then hold the measured state for v.w edges.
  task automatic run_vec(input vec_t v, input int idx);
    int n_trig = 0;
    int first = 0;
    int exp_at;
    rst_ni = 1'b0;
    mode_i = v.mode; meas_false_i = v.pol; sel_mask_i = v.mask; level_i = v.lvl;
    lim_lo_i = v.lo; lim_hi_i = v.hi; chan_i = v.off;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int j = 1; j <= int'(v.w) + 4; j++) begin
      chan_i = (j <= int'(v.w)) ? v.on : v.off;
      @(negedge clk_i);
      if (trig_o) begin
        n_trig++;
        if (first == 0) first = j;
      end
    end
    exp_at = (v.mode == 2'd3) ? int'(v.lo) + 1 : int'(v.w) + 1;
    check(n_trig == (v.fire ? 1 : 0), $sformatf("R%0d", v.req),
          $sformatf("row %0d trigger count", idx), n_trig, v.fire ? 1 : 0);
    if (v.fire)
      check(first == exp_at, $sformatf("R%0d", v.req),
            $sformatf("row %0d trigger cycle", idx), first, exp_at);
  endtask

  initial begin
    // R9: trigger is low after reset
    repeat (3) @(negedge clk_i);
    check(trig_o == 1'b0, "R9", "reset value", int'(trig_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(trig_o == 1'b0, "R9", "idle after reset", int'(trig_o), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R8: a pulse longer than the counter range saturates and still reads as long
    run_vec('{2'd1, 1'b0, 8'hFF, 8'h99, 8'h99, 8'h98, 16'd65534, 16'd0, 32'd70000,
              1'b1, 8'd8}, 100);
    // R8: a wrapping counter would read 70000-65536 = 4464, which is below this limit
    run_vec('{2'd0, 1'b0, 8'hFF, 8'h99, 8'h99, 8'h98, 16'd5000, 16'd0, 32'd70000,
              1'b0, 8'd8}, 101);
    // R6: a limit of zero fires on the first cycle of the pulse, only once
    run_vec('{2'd3, 1'b0, 8'hFF, 8'h42, 8'h42, 8'h40, 16'd0, 16'd0, 32'd6,
              1'b1, 8'd6}, 102);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule